// File: doc/BRIEF.md
# Twin Sensor Exposure and Readout Sequencer

This block times two image sensors that run in slave mode, where the sensor starts nothing by itself and waits for three strobes from outside. The first strobe starts the exposure. The second ends the exposure one row later and starts the frame readout. The third starts each row's readout. A single registered set of these strobes goes to both sensors, so the two cameras expose and read out on the same clock edge.

All timing is counted in rows. A row lasts `ROW_CLKS` pixel clocks, and that figure is the window width plus the horizontal blank. A frame lasts `a` rows and an exposure lasts `b` rows. With 846-clock rows at 27 MHz, a frame of 638 rows gives about 50 frames per second, which matches 50 Hz mains lighting and so avoids lamp flicker in the images.

A host writes a new (`a`, `b`) pair through a single write strobe. The block rejects pairs that are not legal. A legal pair is held back and applied only when the frame wraps, so no frame is ever altered partway through.

Top module: `twin_cam_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all three strobes and `cfg_err` are low. The sequencer restarts at row 0, column 0 with `DEF_FRAME_ROWS` and `DEF_EXP_ROWS` active. The first `line_stb` appears one cycle after the first clock edge with `rst` low.
- R2: `line_stb` is high for exactly one clock in every `ROW_CLKS` clocks, on the first clock of each row.
- R3: With `a` rows active, `frm_stb` pulses for one clock on the first clock of row `a-1`. Its pulses are therefore `a*ROW_CLKS` clocks apart.
- R4: `exp_stb` pulses for one clock on the first clock of row `a-b`. It therefore comes `(b-1)` rows before `frm_stb`, and the exposure lasts `b` rows.
- R5: A write (`cfg_we` high at a clock edge) is accepted when `1 <= b`, `b + 2 < a` and `a >= HEIGHT_ROWS + WAIT_ROWS`. An accepted pair takes effect only from the row-0 that follows the edge where row `a-1` wraps. A write sampled on that same wrap edge waits for the next frame.
- R6: When `b` is shortened, `frm_stb` keeps its row within the frame and only `exp_stb` moves later. The readout window of the previous frame is never cut short.
- R7: A rejected write sets `cfg_err` one cycle later and leaves both the active and the pending values unchanged. An accepted write clears `cfg_err`.
- R8: If several writes land inside one frame, the last accepted one is applied. A rejected write does not cancel an earlier accepted one that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Host write strobe for a new frame/exposure pair |
| cfg_frame_rows | input | ROW_W | Requested frame length `a` in rows |
| cfg_exp_rows | input | ROW_W | Requested exposure length `b` in rows |
| cfg_err | output | 1 | Last write was rejected |
| exp_stb | output | 1 | Exposure-start strobe to both sensors |
| frm_stb | output | 1 | Frame-start (end of exposure, start of readout) strobe to both sensors |
| line_stb | output | 1 | Row readout strobe to both sensors |

## Verification
The hardest case to reach from the ports is a host write sampled on the exact clock edge where the last row of a frame wraps. At that edge, deciding between "this frame" and "next frame" is what separates a correct design from one that is off by a frame. The stimulus finds that edge by first observing `frm_stb`, which marks the first clock of the last row. It then waits `ROW_CLKS-2` more falling edges, so the write is sampled on the wrap edge itself. Other writes are placed between `exp_stb` and `frm_stb` to shorten an exposure that is already running. A rejected write is also placed after an accepted one inside the same frame.

// File: rtl/twin_cam_pkg.sv
package twin_cam_pkg;
  // Legality of a requested frame/exposure pair, in rows.
  function automatic logic pair_legal(input int unsigned a, input int unsigned b,
                                      input int unsigned min_rows);
    return (b >= 1) && (b + 2 < a) && (a >= min_rows);
  endfunction
endpackage

// File: rtl/twin_cam_row_timer.sv
module twin_cam_row_timer #(
  parameter int ROW_CLKS = 846,
  parameter int ROW_W    = 10,
  localparam int COL_W   = (ROW_CLKS > 1) ? $clog2(ROW_CLKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] frame_rows,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             wrap
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_CLKS - 1);

  logic row_end;
  assign row_end = (col == COL_LAST);
  assign wrap    = row_end && (row == frame_rows - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (row_end) begin
      col <= '0;
      row <= wrap ? '0 : row + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  // R3
  row_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    row < frame_rows);
endmodule

// File: rtl/twin_cam_cfg_shadow.sv
module twin_cam_cfg_shadow
  import twin_cam_pkg::*;
#(
  parameter int ROW_W          = 10,
  parameter int DEF_FRAME_ROWS = 638,
  parameter int DEF_EXP_ROWS   = 80,
  parameter int MIN_ROWS       = 482
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ROW_W-1:0] req_a,
  input  logic [ROW_W-1:0] req_b,
  input  logic             wrap,
  output logic [ROW_W-1:0] act_a,
  output logic [ROW_W-1:0] act_b,
  output logic             err
);
  logic [ROW_W-1:0] pend_a, pend_b;
  logic             pend_v;
  logic             req_ok;

  assign req_ok = pair_legal(int'(req_a), int'(req_b), MIN_ROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_a  <= ROW_W'(DEF_FRAME_ROWS);
      act_b  <= ROW_W'(DEF_EXP_ROWS);
      pend_a <= ROW_W'(DEF_FRAME_ROWS);
      pend_b <= ROW_W'(DEF_EXP_ROWS);
      pend_v <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (wrap && pend_v) begin
        act_a <= pend_a;
        act_b <= pend_b;
      end
      if (we && req_ok) begin
        pend_a <= req_a;
        pend_b <= req_b;
        pend_v <= 1'b1;
        err    <= 1'b0;
      end else begin
        if (wrap) pend_v <= 1'b0;
        if (we) err <= 1'b1;
      end
    end
  end

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_a) && $stable(act_b));
  // R5
  active_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (act_b >= 1) && ({1'b0, act_b} + 2 < {1'b0, act_a}));
endmodule

// File: rtl/twin_cam_strobe_gen.sv
module twin_cam_strobe_gen #(
  parameter int ROW_CLKS = 846,
  parameter int ROW_W    = 10,
  localparam int COL_W   = (ROW_CLKS > 1) ? $clog2(ROW_CLKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [ROW_W-1:0] act_a,
  input  logic [ROW_W-1:0] act_b,
  output logic             exp_q,
  output logic             frm_q,
  output logic             line_q
);
  logic row_start;
  assign row_start = (col == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= 1'b0;
      frm_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      line_q <= row_start;
      frm_q  <= row_start && (row == act_a - 1'b1);
      exp_q  <= row_start && (row == act_a - act_b);
    end
  end

  generate
    if (ROW_CLKS > 1) begin : g_narrow
      // R2
      line_single_chk: assert property (@(posedge clk) disable iff (rst)
        line_q |=> !line_q);
    end
  endgenerate
endmodule

// File: rtl/twin_cam_seq.sv
module twin_cam_seq #(
  parameter int ROW_CLKS       = 846,
  parameter int ROW_W          = 10,
  parameter int DEF_FRAME_ROWS = 638,
  parameter int DEF_EXP_ROWS   = 80,
  parameter int HEIGHT_ROWS    = 480,
  parameter int WAIT_ROWS      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_frame_rows,
  input  logic [ROW_W-1:0] cfg_exp_rows,
  output logic             cfg_err,
  output logic             exp_stb,
  output logic             frm_stb,
  output logic             line_stb
);
  localparam int MIN_ROWS = HEIGHT_ROWS + WAIT_ROWS;
  localparam int COL_W    = (ROW_CLKS > 1) ? $clog2(ROW_CLKS) : 1;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row, act_a, act_b;
  logic             wrap;

  twin_cam_row_timer #(.ROW_CLKS(ROW_CLKS), .ROW_W(ROW_W)) u_timer (
    .clk(clk), .rst(rst), .frame_rows(act_a),
    .col(col), .row(row), .wrap(wrap));

  twin_cam_cfg_shadow #(
    .ROW_W(ROW_W), .DEF_FRAME_ROWS(DEF_FRAME_ROWS),
    .DEF_EXP_ROWS(DEF_EXP_ROWS), .MIN_ROWS(MIN_ROWS)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .req_a(cfg_frame_rows),
    .req_b(cfg_exp_rows), .wrap(wrap),
    .act_a(act_a), .act_b(act_b), .err(cfg_err));

  twin_cam_strobe_gen #(.ROW_CLKS(ROW_CLKS), .ROW_W(ROW_W)) u_stb (
    .clk(clk), .rst(rst), .col(col), .row(row),
    .act_a(act_a), .act_b(act_b),
    .exp_q(exp_stb), .frm_q(frm_stb), .line_q(line_stb));

  // R3
  frame_on_row_start_chk: assert property (@(posedge clk) disable iff (rst)
    frm_stb |-> line_stb);
  // R4
  exp_on_row_start_chk: assert property (@(posedge clk) disable iff (rst)
    exp_stb |-> line_stb);
endmodule

// File: tb/twin_cam_seq_test.sv
module twin_cam_seq_test;
  localparam int RC   = 6;
  localparam int RW   = 8;
  localparam int DA   = 10;
  localparam int DB   = 3;
  localparam int HGT  = 4;
  localparam int WT   = 2;
  localparam int MINR = HGT + WT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [RW-1:0] ra = '0, rb = '0;
  logic err, exps, frms, lines;

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference state
  int m_col, m_row, m_a, m_b, m_pa, m_pb;
  bit m_pv, m_err, e_line, e_frm, e_exp;

  always #5 clk = ~clk;

  twin_cam_seq #(.ROW_CLKS(RC), .ROW_W(RW), .DEF_FRAME_ROWS(DA),
    .DEF_EXP_ROWS(DB), .HEIGHT_ROWS(HGT), .WAIT_ROWS(WT)) uut (
    .clk(clk), .rst(rst), .cfg_we(we), .cfg_frame_rows(ra),
    .cfg_exp_rows(rb), .cfg_err(err), .exp_stb(exps),
    .frm_stb(frms), .line_stb(lines));

  always @(posedge clk) begin
    bit last;
    if (rst) begin
      m_col = 0; m_row = 0; m_a = DA; m_b = DB; m_pv = 0; m_err = 0;
      e_line = 0; e_frm = 0; e_exp = 0;
    end else begin
      e_line = (m_col == 0);
      e_frm  = (m_col == 0) && (m_row == m_a - 1);
      e_exp  = (m_col == 0) && (m_row == m_a - m_b);
      last = (m_col == RC - 1) && (m_row == m_a - 1);
      if (m_col == RC - 1) begin
        m_col = 0;
        m_row = last ? 0 : m_row + 1;
      end else m_col++;
      if (last && m_pv) begin m_a = m_pa; m_b = m_pb; end
      if (last) m_pv = 0;
      if (we) begin
        if (rb >= 1 && int'(rb) + 2 < int'(ra) && ra >= MINR) begin
          m_pa = ra; m_pb = rb; m_pv = 1; m_err = 0;
        end else m_err = 1;
      end
    end
  end

  task automatic chk(string tag, bit act, bit expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s (%s) cyc %0d: actual %0b expected %0b", tag, phase, cyc, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("R2 line_stb", lines, e_line);
    chk("R3 frm_stb", frms, e_frm);
    chk("R4 exp_stb", exps, e_exp);
    chk("R7 cfg_err", err, m_err);
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(int a, int b);
    ra = RW'(a); rb = RW'(b); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_frm();
    do @(negedge clk); while (frms !== 1'b1);
  endtask

  task automatic wait_exp();
    do @(negedge clk); while (exps !== 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    rst = 1'b0;
    repeat (3 * DA * RC) @(negedge clk);
    // R5: legal write mid-frame, longer exposure
    phase = "R5";
    repeat (7) @(negedge clk);
    wr(12, 6);
    repeat (3 * 12 * RC) @(negedge clk);
    // R6: shorten while exposure running
    phase = "R6";
    wait_exp();
    @(negedge clk);
    wr(12, 2);
    repeat (3 * 12 * RC) @(negedge clk);
    // R7: illegal writes (b too large, a too small, b zero)
    phase = "R7";
    wr(12, 10);
    repeat (5) @(negedge clk);
    wr(5, 1);
    repeat (5) @(negedge clk);
    wr(12, 0);
    repeat (2 * 12 * RC) @(negedge clk);
    // R8: accepted then rejected in one frame; last accepted wins
    phase = "R8";
    wr(9, 4);
    wr(11, 5);
    wr(7, 7);
    repeat (3 * 11 * RC) @(negedge clk);
    // R5: write sampled on the wrap edge itself
    phase = "R5 wrap";
    wait_frm();
    repeat (RC - 2) @(negedge clk);
    wr(8, 5);
    repeat (3 * 11 * RC) @(negedge clk);
    // R1: reset mid-frame
    phase = "R1 reset";
    wait_exp();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2 * DA * RC) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule